// File: doc/BRIEF.md
# Buffered SPI Master with Bus-to-Frame Repacking

This block is a full-duplex SPI master that sits behind a small register port. The host writes transmit data in units of a selectable bus width (8, 16 or 32 bits). Each write is split into bytes, most significant byte first, and the bytes go into a byte-wide transmit queue. The serial engine takes frames of 8 or 16 bits from that queue. Each frame is shifted out MSB first on MOSI, and MISO is captured in the same SCK cycles. Received frames land in a byte-wide receive queue, and the host reads them back one frame per read.

The host sets the clock polarity and phase, the SCK divider, both widths and the chip-select level through one control register. A frame starts only while chip select is asserted and the transmit queue holds a whole frame. Received data that cannot be stored is dropped, and a sticky flag records the loss.

Top module: `spi_pack_master`

## Requirements
- R1: While no frame is in progress, `sck` rests at the polarity bit (control bit 8): low for 0, high for 1.
- R2: With the phase bit (control bit 9) at 0, the MSB is on `mosi` before the first SCK edge of a frame. `miso` is sampled on every leading edge and `mosi` changes on the trailing edges.
- R3: With the phase bit at 1, `mosi` changes on every leading edge and `miso` is sampled on every trailing edge.
- R4: A frame is 8 SCK cycles when control bit 10 is 0 and 16 cycles when it is 1. Bits are sent and received MSB first, both at once.
- R5: One SCK period is 2*(div+1) system clocks, where div is control bits [7:0].
- R6: A write to address 1 pushes the low 1, 2 or 4 bytes of `reg_wdata` into the transmit queue, MSB byte first. The count follows the bus-width code in control bits [12:11] (0, 1 or 2). A 16-bit frame takes its high byte from the queue first. A write that does not fit in the 16-byte queue is dropped whole.
- R7: A control write is rejected, and the previous setting kept, when the bus-width code is 3 or the bus width is narrower than the frame.
- R8: A read of address 1 pops one frame from the receive queue, right-aligned in `reg_rdata`. When less than a frame is stored, the read returns 0 and pops nothing.
- R9: A frame that finishes while the 16-byte receive queue lacks room for it is discarded, and status bit 5 (overrun) is set. The bit stays set until a write to address 2 has bit 5 high.
- R10: `cs_n` follows control bit 13, which resets to 1. No frame starts while `cs_n` is high or while the transmit queue holds less than one frame.
- R11: Status (read of address 2) holds busy in bit 0, transmit empty in 1, transmit full in 2, receive empty in 3, receive full in 4, overrun in 5, the transmit byte count in [10:6] and the receive byte count in [15:11]. Busy is high for the whole of a frame.
- R12: After reset the status reads 0x0000000A, the control reads 0x00002000 and `sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A wrong edge choice in the engine shows up on the bench's own slave at once. That slave shifts its reply right after each sample edge, so a master that samples on the other edge reads the next bit, and the read-back frame is wrong. A wrong divider or edge count shows up as a leading-edge spacing or a frame length that differs from 2*(div+1), within the first frame. A broken byte count or pointer in either queue appears in the status counts and in misordered bytes in the first frames after a fill, an overflow or a drain. A lost overrun flag or one that never clears is visible in the next status read.

// File: rtl/spi_pack_master.sv
module spi_pack_master #(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int PW  = $clog2(FIFO_DEPTH);
  localparam int CW  = PW + 1;
  localparam int CW1 = CW + 1;
  localparam int P_CPOL = DIV_W;
  localparam int P_CPHA = DIV_W + 1;
  localparam int P_C16  = DIV_W + 2;
  localparam int P_BW   = DIV_W + 3;
  localparam int P_CS   = DIV_W + 5;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [CW:0] DEPTH_V = CW1'(FIFO_DEPTH);

  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q, c16_q, cs_q;
  logic [1:0]       bw_q;

  wire [1:0] w_bw   = reg_wdata[P_BW +: 2];
  wire       w_c16  = reg_wdata[P_C16];
  wire       cfg_ok = (w_bw != 2'd3) && !(w_bw == 2'd0 && w_c16);
  wire       cfg_wr = reg_wr && reg_addr == A_CTRL;

  wire [CW:0] bus_n = (bw_q == 2'd0) ? CW1'(1) : (bw_q == 2'd1) ? CW1'(2) : CW1'(4);
  wire [CW:0] frm_n = c16_q ? CW1'(2) : CW1'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; c16_q <= 1'b0; bw_q <= 2'd0; cs_q <= 1'b1;
    end else if (cfg_wr && cfg_ok) begin
      div_q  <= reg_wdata[DIV_W-1:0];
      cpol_q <= reg_wdata[P_CPOL];
      cpha_q <= reg_wdata[P_CPHA];
      c16_q  <= w_c16;
      bw_q   <= w_bw;
      cs_q   <= reg_wdata[P_CS];
    end

  // transmit byte queue
  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW:0]   tx_cnt;
  logic [7:0]    wb [4];
  for (genvar g = 0; g < 4; g++) begin : g_wb
    assign wb[g] = reg_wdata[8*g +: 8];
  end

  logic busy_q, done_q;
  wire  tx_push = reg_wr && reg_addr == A_DATA && (DEPTH_V - tx_cnt) >= bus_n;
  wire  start   = !busy_q && !done_q && !cs_q && tx_cnt >= frm_n;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (tx_push && i < int'(bus_n))
        tx_mem[tx_wp + PW'(i)] <= wb[2'(int'(bus_n) - 1 - i)];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + bus_n[PW-1:0];
      if (start)   tx_rp <= tx_rp + frm_n[PW-1:0];
      tx_cnt <= tx_cnt + (tx_push ? bus_n : '0) - (start ? frm_n : '0);
    end

  // serial engine
  logic [DIV_W-1:0] dcnt;
  logic [4:0]       ecnt;
  logic             lead, mosi_q;
  logic [15:0]      sh, rxsh;

  wire [15:0] ld     = c16_q ? {tx_mem[tx_rp], tx_mem[tx_rp + PW'(1)]} : {tx_mem[tx_rp], 8'h00};
  wire        tick   = busy_q && dcnt == div_q;
  wire        is_ld  = !ecnt[0];
  wire        last_e = ecnt == (c16_q ? 5'd31 : 5'd15);
  wire        drive  = tick && (cpha_q ? is_ld : (!is_ld && !last_e));
  wire        smp    = tick && (cpha_q ? !is_ld : is_ld);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; dcnt <= '0; ecnt <= '0;
      lead <= 1'b0; mosi_q <= 1'b0; sh <= '0; rxsh <= '0;
    end else begin
      done_q <= tick && last_e;
      if (start) begin
        busy_q <= 1'b1;
        dcnt   <= '0;
        ecnt   <= '0;
        lead   <= 1'b0;
        if (!cpha_q) begin
          mosi_q <= ld[15];
          sh     <= {ld[14:0], 1'b0};
        end else
          sh <= ld;
      end else if (busy_q) begin
        if (drive) begin
          mosi_q <= sh[15];
          sh     <= {sh[14:0], 1'b0};
        end
        if (smp) rxsh <= {rxsh[14:0], miso};
        if (tick) begin
          dcnt <= '0;
          lead <= ~lead;
          ecnt <= ecnt + 5'd1;
          if (last_e) busy_q <= 1'b0;
        end else
          dcnt <= dcnt + DIV_W'(1);
      end
    end

  // receive byte queue
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW:0]   rx_cnt;
  logic          ovr_q;

  wire rx_fits = (DEPTH_V - rx_cnt) >= frm_n;
  wire rx_push = done_q && rx_fits;
  wire rx_have = rx_cnt >= frm_n;
  wire rx_pop  = reg_rd && reg_addr == A_DATA && rx_have;
  wire ovr_clr = reg_wr && reg_addr == A_STAT && reg_wdata[5];

  always_ff @(posedge clk)
    if (rx_push) begin
      if (c16_q) begin
        rx_mem[rx_wp]           <= rxsh[15:8];
        rx_mem[rx_wp + PW'(1)]  <= rxsh[7:0];
      end else
        rx_mem[rx_wp] <= rxsh[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; ovr_q <= 1'b0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + frm_n[PW-1:0];
      if (rx_pop)  rx_rp <= rx_rp + frm_n[PW-1:0];
      rx_cnt <= rx_cnt + (rx_push ? frm_n : '0) - (rx_pop ? frm_n : '0);
      if (done_q && !rx_fits) ovr_q <= 1'b1;
      else if (ovr_clr)       ovr_q <= 1'b0;
    end

  wire [31:0] rx_word = !rx_have ? 32'h0 :
                        c16_q ? {16'h0, rx_mem[rx_rp], rx_mem[rx_rp + PW'(1)]} :
                                {24'h0, rx_mem[rx_rp]};

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = 32'({cs_q, bw_q, c16_q, cpha_q, cpol_q, div_q});
      A_DATA:  reg_rdata = rx_word;
      A_STAT:  reg_rdata = 32'({rx_cnt[CW-1:0], tx_cnt[CW-1:0], ovr_q,
                                rx_cnt == DEPTH_V, rx_cnt == '0,
                                tx_cnt == DEPTH_V, tx_cnt == '0, busy_q});
      default: reg_rdata = 32'h0;
    endcase

  assign sck  = lead ^ cpol_q;
  assign mosi = mosi_q;
  assign cs_n = cs_q;
endmodule

module spi_pack_master_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic        mosi,
  input logic        cs_n,
  input logic        busy,
  input logic        cpol,
  input logic        tick,
  input logic        drive,
  input logic        cfg_wr,
  input logic        ovr,
  input logic        ovr_clr,
  input logic [CW:0] tx_cnt,
  input logic [CW:0] rx_cnt
);
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);
  a_r5_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !cfg_wr) |=> $stable(sck));
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drive) |=> $stable(mosi));
  a_r10_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !busy && !cfg_wr) |=> !busy);
  a_r6_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= FIFO_DEPTH);
  a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_cnt) <= FIFO_DEPTH);
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);
endmodule

bind spi_pack_master spi_pack_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy_q),
  .cpol(cpol_q), .tick(tick), .drive(drive), .cfg_wr(cfg_wr), .ovr(ovr_q),
  .ovr_clr(ovr_clr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/spi_pack_master_bench.sv
module spi_pack_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, cs_n;
  logic        miso = 1'b0;

  spi_pack_master u_spi_pack_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench slave and bus monitor state
  bit          cpol_b = 0, cpha_b = 0;
  int          nb = 8, fr = 0, bitc = 0, per = -1, last_lead = 0;
  logic [15:0] mon [64];
  logic        prev_sck = 1'b0, prev_mosi = 1'b0;

  function automatic logic [15:0] sl(int k);
    return 16'hA53C ^ 16'(k * 16'h1357);
  endfunction

  function automatic logic [31:0] cfg(int dv, bit cp, bit ch, bit c16, logic [1:0] bw, bit cs);
    return {18'b0, cs, bw, c16, ch, cp, 8'(dv)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !cs_n && sck != prev_sck) begin
      if (prev_sck == cpol_b) begin
        if (bitc != 0) per = cyc - last_lead;
        last_lead = cyc;
      end
      if ((prev_sck == cpol_b) == !cpha_b) begin
        mon[fr] = {mon[fr][14:0], prev_mosi};
        bitc++;
        if (bitc == nb) begin fr++; bitc = 0; end
      end
    end
    begin
      logic [15:0] s;
      s = sl(fr);
      miso = s[nb-1-bitc];
    end
    prev_sck = sck;
    prev_mosi = mosi;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd2, r);
      if (r[0] == 1'b0 && r[10:6] == 5'd0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic mon_clear(input bit cp, input bit ch, input int bits);
    cpol_b = cp; cpha_b = ch; nb = bits; fr = 0; bitc = 0; per = -1;
    for (int i = 0; i < 64; i++) mon[i] = '0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd(2'd2, r);  chk("R12", "status after reset", r, 32'h0000_000A);
    rd(2'd0, r);  chk("R12", "control after reset", r, 32'h0000_2000);
    chk("R12", "sck after reset", 32'(sck), 32'd0);
    chk("R10", "cs_n after reset", 32'(cs_n), 32'd1);
  endtask

  task automatic xfer(input string tag, input int dv, input bit cp, input bit ch, input bit c16,
                      input logic [1:0] bw, input logic [31:0] w0, input logic [31:0] w1, input int nw);
    int bb, fb, ne;
    logic [7:0]  eb [8];
    logic [31:0] r, w, ex;
    logic [15:0] msk;
    bb = (bw == 2'd0) ? 1 : (bw == 2'd1) ? 2 : 4;
    fb = c16 ? 2 : 1;
    msk = c16 ? 16'hFFFF : 16'h00FF;
    ne = 0;
    mon_clear(cp, ch, c16 ? 16 : 8);
    wr(2'd0, cfg(dv, cp, ch, c16, bw, 1));
    for (int k = 0; k < nw; k++) begin
      w = (k == 0) ? w0 : w1;
      wr(2'd1, w);
      for (int i = bb - 1; i >= 0; i--) begin eb[ne] = w[8*i +: 8]; ne++; end
    end
    wr(2'd0, cfg(dv, cp, ch, c16, bw, 0));
    repeat (4) @(negedge clk);
    rd(2'd2, r);
    chk("R11", {tag, " busy during frame"}, 32'(r[0]), 32'd1);
    wait_idle();
    wr(2'd0, cfg(dv, cp, ch, c16, bw, 1));
    chk("R1", {tag, " sck idle level"}, 32'(sck), 32'(cp));
    for (int k = 0; k < ne / fb; k++) begin
      ex = c16 ? {16'h0, eb[2*k], eb[2*k+1]} : {24'h0, eb[k]};
      chk(ch ? "R3" : "R2", {tag, " mosi frame (R4 R6)"}, 32'(mon[k]), ex);
      rd(2'd1, r);
      chk("R4", {tag, " miso frame read (R8)"}, r, 32'(sl(k) & msk));
    end
    chk("R5", {tag, " sck period"}, 32'(per), 32'(2 * (dv + 1)));
  endtask

  task automatic t_cfg_reject();
    logic [31:0] r;
    wr(2'd0, cfg(5, 1, 0, 0, 2'd1, 1));
    rd(2'd0, r); chk("R7", "valid config accepted", r, cfg(5, 1, 0, 0, 2'd1, 1));
    wr(2'd0, cfg(2, 0, 1, 1, 2'd0, 1));
    rd(2'd0, r); chk("R7", "byte bus with 16-bit frame rejected", r, cfg(5, 1, 0, 0, 2'd1, 1));
    wr(2'd0, cfg(2, 0, 1, 0, 2'd3, 0));
    rd(2'd0, r); chk("R7", "bus code 3 rejected", r, cfg(5, 1, 0, 0, 2'd1, 1));
    chk("R1", "sck idle high with polarity 1", 32'(sck), 32'd1);
    chk("R10", "cs_n kept high after rejection", 32'(cs_n), 32'd1);
  endtask

  task automatic t_fill_overrun();
    logic [31:0] r;
    mon_clear(0, 0, 8);
    wr(2'd0, cfg(1, 0, 0, 0, 2'd0, 1));
    for (int k = 0; k < 17; k++) wr(2'd1, 32'(k + 1));
    rd(2'd2, r);
    chk("R6", "tx count after 17 byte writes", 32'(r[10:6]), 32'd16);
    chk("R6", "tx full flag", 32'(r[2]), 32'd1);
    chk("R10", "no frame while cs_n high", 32'(r[0]), 32'd0);
    wr(2'd0, cfg(1, 0, 0, 0, 2'd0, 0));
    wait_idle();
    rd(2'd2, r);
    chk("R9", "rx count after 16 frames", 32'(r[15:11]), 32'd16);
    chk("R9", "no overrun yet", 32'(r[5]), 32'd0);
    chk("R11", "rx full flag", 32'(r[4]), 32'd1);
    chk("R6", "last queued byte sent", 32'(mon[15]), 32'd16);
    wr(2'd1, 32'h77);
    wait_idle();
    rd(2'd2, r);
    chk("R9", "overrun set", 32'(r[5]), 32'd1);
    chk("R9", "rx count held at 16", 32'(r[15:11]), 32'd16);
    rd(2'd1, r);
    chk("R9", "oldest frame kept", r, 32'(sl(0) & 16'h00FF));
    wr(2'd2, 32'h20);
    rd(2'd2, r);
    chk("R9", "overrun cleared", 32'(r[5]), 32'd0);
    chk("R8", "read popped one byte", 32'(r[15:11]), 32'd15);
    for (int k = 1; k < 16; k++) begin
      rd(2'd1, r);
      chk("R8", "drain order", r, 32'(sl(k) & 16'h00FF));
    end
    rd(2'd1, r);
    chk("R8", "empty read returns zero", r, 32'd0);
    rd(2'd2, r);
    chk("R8", "empty read pops nothing", 32'(r[15:11]), 32'd0);
    chk("R11", "rx empty flag", 32'(r[3]), 32'd1);
    wr(2'd0, cfg(1, 0, 0, 0, 2'd0, 1));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    xfer("mode0 8b bus8",   1, 0, 0, 0, 2'd0, 32'hA5, 32'h3C, 2);
    xfer("mode3 16b bus32", 2, 1, 1, 1, 2'd2, 32'h1234_5678, 32'h0, 1);
    xfer("mode1 8b bus16",  0, 0, 1, 0, 2'd1, 32'hBEEF, 32'h0, 1);
    xfer("mode2 16b bus16", 3, 1, 0, 1, 2'd1, 32'hC0DE, 32'h0F0F, 2);
    t_cfg_reject();
    t_fill_overrun();
    finish_run();
  end
endmodule